// File: doc/BRIEF.md
# Self-Test Session Sequencer

This block orders a logic self-test run made of several sessions. Each session holds one capture clock sequence and applies a programmable number of patterns with it. Before each session the block opens a programming window, so an external waveform generator can be loaded with a new capture sequence. Inside a session the block alternates two phases. In the slow scan phase the chains are shifted with a divided shift pulse. In the capture phase the chain mode is dropped and the waveform generator is told to fire its capture burst. Captured responses go to the signature register during the next scan phase. That phase may belong to the same session or to the next one. A last unload-only scan phase closes the run.

All clocks are modelled as single-cycle enables on the one system clock. The divide ratio, chain length, patterns per session and session count are register inputs. They are sampled when the run is started, so one netlist can serve many test programs.

Top module: `selftest_seq`

## Requirements
- R1: While reset is high, and after it is released, every output is low and the block stays idle until `go` is pulsed.
- R2: A `go` pulse while idle or finished starts a run. It latches all four configuration inputs. Configuration changes and further `go` pulses during a run have no effect on that run.
- R3: Each session opens with `prog_window` high. The window stays high until `prog_done` arrives, and the scan phase then follows. Exactly `cfg_sess` windows occur per run. `prog_done` outside a window is ignored.
- R4: During a scan phase `chain_mode` is high and `shift_pulse` fires once every `cfg_div` cycles, `cfg_chain` times per phase. A value of 0 in either field acts as 1.
- R5: During capture `chain_mode` is low. `capt_go` is a single-cycle pulse at the start of each capture, and the block then waits for `capt_done`. `capt_done` outside a capture is ignored.
- R6: Each session applies `cfg_pats` patterns, and a run has `cfg_sess` sessions. A value of 0 in either field acts as 1, so a run has `cfg_pats*cfg_sess` captures.
- R7: `sig_unload` fires together with `shift_pulse` in every scan phase that follows a capture. This includes the first load of a later session and the final phase. It never fires in the first load of a run, so a run has `cfg_chain*cfg_pats*cfg_sess` unload pulses.
- R8: After the final unload-only phase of `cfg_chain` shifts, the run has `cfg_chain*(cfg_pats*cfg_sess+1)` shift pulses in total. `test_active` then falls, and `run_complete` stays high until the next `go`.
- R9: While `test_active` is low (functional clocking), `chain_mode`, `shift_pulse`, `prog_window` and `capt_go` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Run start pulse |
| cfg_div | input | DIV_W | Shift divide ratio |
| cfg_chain | input | LEN_W | Shift pulses per scan phase |
| cfg_pats | input | PAT_W | Patterns per session |
| cfg_sess | input | SES_W | Sessions per run |
| prog_done | input | 1 | Waveform programming finished pulse |
| capt_done | input | 1 | Capture burst finished pulse |
| test_active | output | 1 | High: test enables drive the core |
| chain_mode | output | 1 | High: scan shift mode; low: capture mode |
| shift_pulse | output | 1 | Divided shift clock enable |
| prog_window | output | 1 | Waveform generator programming window |
| capt_go | output | 1 | Capture burst request pulse |
| sig_unload | output | 1 | Response unload strobe to the signature register |
| run_complete | output | 1 | Run finished flag |

## Verification
The hardest case to reach from the ports is a handshake pulse that arrives in the wrong phase. Examples are a `capt_done` during a scan phase, or a `prog_done` while no programming window is open. The bench therefore has a mode where its stand-in waveform generator sends such stray pulses periodically throughout a run. It then checks that shift, unload, capture and window counts still match the configuration. A second hard case is a configuration change together with a repeated `go` in mid-run. This is driven explicitly, and the totals are checked against the values latched at the start.

// File: rtl/selftest_pkg.sv
package selftest_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_SHIFT,
    ST_CAPT,
    ST_FLUSH,
    ST_DONE
  } seq_state_t;
endpackage

// File: rtl/st_divider.sv
module st_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] lim_m1,
  output logic         tick
);
  logic [W-1:0] cnt;

  assign tick = run && (cnt == lim_m1);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/st_counter.sv
module st_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] lim_m1,
  output logic         last
);
  logic [W-1:0] cnt;

  assign last = (cnt == lim_m1);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= last ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/selftest_seq.sv
module selftest_seq
  import selftest_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int LEN_W = 8,
  parameter int PAT_W = 16,
  parameter int SES_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [LEN_W-1:0] cfg_chain,
  input  logic [PAT_W-1:0] cfg_pats,
  input  logic [SES_W-1:0] cfg_sess,
  input  logic             prog_done,
  input  logic             capt_done,
  output logic             test_active,
  output logic             chain_mode,
  output logic             shift_pulse,
  output logic             prog_window,
  output logic             capt_go,
  output logic             sig_unload,
  output logic             run_complete
);
  seq_state_t st;
  logic [DIV_W-1:0] div_m1;
  logic [LEN_W-1:0] len_m1;
  logic [PAT_W-1:0] pat_m1;
  logic [SES_W-1:0] ses_m1;
  logic unl_pend;
  logic capt_sent;

  logic launch, scan_run, tick, sh_last, pat_last, ses_last, pat_inc;

  assign launch   = go && (st == ST_IDLE || st == ST_DONE);
  assign scan_run = (st == ST_SHIFT) || (st == ST_FLUSH);
  assign pat_inc  = (st == ST_CAPT) && capt_sent && capt_done;

  function automatic logic [DIV_W-1:0] m1_div(input logic [DIV_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction
  function automatic logic [LEN_W-1:0] m1_len(input logic [LEN_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction
  function automatic logic [PAT_W-1:0] m1_pat(input logic [PAT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction
  function automatic logic [SES_W-1:0] m1_ses(input logic [SES_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  st_divider #(.W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(scan_run), .lim_m1(div_m1), .tick(tick)
  );

  st_counter #(.W(LEN_W)) u_shcnt (
    .clk(clk), .rst(rst), .clr(launch), .inc(tick), .lim_m1(len_m1), .last(sh_last)
  );

  st_counter #(.W(PAT_W)) u_patcnt (
    .clk(clk), .rst(rst), .clr(launch), .inc(pat_inc), .lim_m1(pat_m1), .last(pat_last)
  );

  st_counter #(.W(SES_W)) u_sescnt (
    .clk(clk), .rst(rst), .clr(launch), .inc(pat_inc && pat_last),
    .lim_m1(ses_m1), .last(ses_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      div_m1    <= '0;
      len_m1    <= '0;
      pat_m1    <= '0;
      ses_m1    <= '0;
      unl_pend  <= 1'b0;
      capt_sent <= 1'b0;
    end else begin
      case (st)
        ST_IDLE, ST_DONE: begin
          if (go) begin
            div_m1   <= m1_div(cfg_div);
            len_m1   <= m1_len(cfg_chain);
            pat_m1   <= m1_pat(cfg_pats);
            ses_m1   <= m1_ses(cfg_sess);
            unl_pend <= 1'b0;
            st       <= ST_PROG;
          end
        end
        ST_PROG: begin
          if (prog_done) st <= ST_SHIFT;
        end
        ST_SHIFT: begin
          capt_sent <= 1'b0;
          if (tick && sh_last) st <= ST_CAPT;
        end
        ST_CAPT: begin
          capt_sent <= 1'b1;
          if (pat_inc) begin
            unl_pend  <= 1'b1;
            capt_sent <= 1'b0;
            if (!pat_last)     st <= ST_SHIFT;
            else if (ses_last) st <= ST_FLUSH;
            else               st <= ST_PROG;
          end
        end
        ST_FLUSH: begin
          if (tick && sh_last) st <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign test_active  = (st == ST_PROG) || (st == ST_SHIFT) ||
                        (st == ST_CAPT) || (st == ST_FLUSH);
  assign chain_mode   = (st == ST_PROG) || scan_run;
  assign prog_window  = (st == ST_PROG);
  assign shift_pulse  = tick;
  assign sig_unload   = tick && unl_pend;
  assign capt_go      = (st == ST_CAPT) && !capt_sent;
  assign run_complete = (st == ST_DONE);
endmodule

// File: rtl/selftest_seq_chk.sv
module selftest_seq_chk (
  input logic clk,
  input logic rst,
  input logic test_active,
  input logic chain_mode,
  input logic shift_pulse,
  input logic prog_window,
  input logic capt_go,
  input logic sig_unload,
  input logic run_complete
);
  // R4
  shift_in_chain_chk: assert property (@(posedge clk) disable iff (rst)
    shift_pulse |-> chain_mode && !prog_window);
  // R5
  capt_low_chain_chk: assert property (@(posedge clk) disable iff (rst)
    capt_go |-> !chain_mode && test_active);
  // R5
  capt_single_chk: assert property (@(posedge clk) disable iff (rst)
    capt_go |=> !capt_go);
  // R7
  unload_with_shift_chk: assert property (@(posedge clk) disable iff (rst)
    sig_unload |-> shift_pulse);
  // R9
  functional_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !test_active |-> !chain_mode && !shift_pulse && !prog_window && !capt_go);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    run_complete |-> !test_active);
  // R3
  window_into_scan_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(prog_window) |-> chain_mode && test_active);
endmodule

bind selftest_seq selftest_seq_chk u_chk (
  .clk(clk), .rst(rst), .test_active(test_active), .chain_mode(chain_mode),
  .shift_pulse(shift_pulse), .prog_window(prog_window), .capt_go(capt_go),
  .sig_unload(sig_unload), .run_complete(run_complete)
);

// File: tb/selftest_seq_tb.sv
module selftest_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go = 1'b0;
  logic [3:0]  cfg_div = '0;
  logic [7:0]  cfg_chain = '0;
  logic [15:0] cfg_pats = '0;
  logic [3:0]  cfg_sess = '0;
  logic prog_done = 1'b0;
  logic capt_done = 1'b0;
  logic test_active, chain_mode, shift_pulse, prog_window, capt_go, sig_unload, run_complete;

  always #(CLK_PERIOD/2) clk = ~clk;

  selftest_seq u_dut (
    .clk(clk), .rst(rst), .go(go), .cfg_div(cfg_div), .cfg_chain(cfg_chain),
    .cfg_pats(cfg_pats), .cfg_sess(cfg_sess), .prog_done(prog_done),
    .capt_done(capt_done), .test_active(test_active), .chain_mode(chain_mode),
    .shift_pulse(shift_pulse), .prog_window(prog_window), .capt_go(capt_go),
    .sig_unload(sig_unload), .run_complete(run_complete)
  );

  int n_checks = 0;
  int n_fail = 0;
  int n_shift, n_unl, n_capt, n_win, min_gap, n_bad, cyc, last_sh;
  logic prev_win;
  int capt_cd = 0;
  int prog_cd = 0;
  logic stray = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    n_shift = 0; n_unl = 0; n_capt = 0; n_win = 0; n_bad = 0;
    min_gap = 1000000; last_sh = -1;
  endtask

  // monitor and stand-in waveform generator, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    capt_done = 1'b0;
    prog_done = 1'b0;
    if (!rst) begin
      if (shift_pulse) begin
        n_shift++;
        if (last_sh >= 0 && (cyc - last_sh) < min_gap) min_gap = cyc - last_sh;
        last_sh = cyc;
      end
      if (sig_unload) n_unl++;
      if (capt_go) begin n_capt++; capt_cd = 3; end
      if (prog_window && !prev_win) begin n_win++; prog_cd = 2; end
      if (!test_active && (chain_mode || shift_pulse || prog_window || capt_go)) n_bad++;
      if (capt_cd > 0) begin
        capt_cd--;
        if (capt_cd == 0) capt_done = 1'b1;
      end
      if (prog_cd > 0) begin
        prog_cd--;
        if (prog_cd == 0) prog_done = 1'b1;
      end
      if (stray && test_active) begin
        if (chain_mode && !prog_window && (cyc % 5 == 0)) capt_done = 1'b1;
        if (!prog_window && (cyc % 3 == 0)) prog_done = 1'b1;
      end
    end
    prev_win = prog_window;
  end

  task automatic do_run(input int d, input int l, input int p, input int s,
                        input bit stray_on, input bit poke, input string tag);
    int de, le, pe, se, t;
    de = (d == 0) ? 1 : d; le = (l == 0) ? 1 : l;
    pe = (p == 0) ? 1 : p; se = (s == 0) ? 1 : s;
    @(negedge clk);
    clear_mon();
    stray = stray_on;
    cfg_div = d[3:0]; cfg_chain = l[7:0]; cfg_pats = p[15:0]; cfg_sess = s[3:0];
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    // R2 R3 run starts in programming window
    check(test_active && prog_window && !run_complete, {tag, " R2 start"},
          {test_active, prog_window, run_complete}, 3'b110);
    t = 0;
    while (!run_complete && t < 20000) begin
      @(negedge clk);
      t++;
      if (poke && t == 15) begin
        cfg_div = 4'd5; cfg_chain = 8'd5; cfg_pats = 16'd5; cfg_sess = 4'd5;
        go = 1'b1;
      end else go = 1'b0;
    end
    stray = 1'b0;
    check(run_complete, {tag, " R8 watchdog"}, t, 20000);
    check(n_shift == le * (pe * se + 1), {tag, " R4 R8 shift total"}, n_shift, le * (pe * se + 1));
    check(n_unl == le * pe * se, {tag, " R7 unload total"}, n_unl, le * pe * se);
    check(n_capt == pe * se, {tag, " R5 R6 capture total"}, n_capt, pe * se);
    check(n_win == se, {tag, " R3 window total"}, n_win, se);
    if (le >= 2) check(min_gap == de, {tag, " R4 shift spacing"}, min_gap, de);
    check(n_bad == 0, {tag, " R9 functional quiet"}, n_bad, 0);
    repeat (5) @(negedge clk);
    check(run_complete && !test_active && !chain_mode, {tag, " R8 done hold"},
          {run_complete, test_active, chain_mode}, 3'b100);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check({test_active, chain_mode, shift_pulse, prog_window, capt_go, sig_unload, run_complete} == 7'b0,
          "R1 outputs in reset", {test_active, chain_mode, prog_window, run_complete}, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check({test_active, chain_mode, prog_window, run_complete} == 4'b0,
          "R1 idle after reset", {test_active, chain_mode, prog_window, run_complete}, 0);
  endtask

  task automatic t_midreset();
    @(negedge clk);
    cfg_div = 4'd2; cfg_chain = 8'd4; cfg_pats = 16'd3; cfg_sess = 4'd2;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check({test_active, chain_mode, shift_pulse, capt_go, run_complete} == 5'b0,
          "R1 reset mid-run", {test_active, chain_mode, shift_pulse, capt_go, run_complete}, 0);
    rst = 1'b0;
    capt_cd = 0; prog_cd = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    cyc = 0; prev_win = 1'b0;
    clear_mon();
    t_reset();
    do_run(2, 3, 2, 2, 1'b0, 1'b0, "basic");
    do_run(1, 1, 1, 1, 1'b0, 1'b0, "single");
    do_run(0, 0, 0, 0, 1'b0, 1'b0, "zero");
    do_run(3, 2, 3, 2, 1'b1, 1'b0, "stray");
    do_run(1, 4, 1, 3, 1'b0, 1'b1, "poke");
    t_midreset();
    do_run(2, 2, 2, 1, 1'b0, 1'b0, "after-reset");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule